// File: doc/BRIEF.md
# Timing Word Sequencer with Embedded Hold

The block plays back a table of 24-bit timing words to produce the digital clocking pattern for an imaging array. Each stored word has two parts: a 16-bit pattern that is put onto a registered output bus for downstream clock-driver and video boards, and an 8-bit hold field that says how long that pattern stays on the bus before the next word is fetched. The timing of the waveform is therefore carried inside the table itself.

A write port fills the 1024-entry table. A run command gives a start address and a word count. The sequencer then walks through consecutive addresses, wrapping at the end of the table. It holds each pattern for its own computed interval. When the last interval ends it pulses a done flag for one cycle. A busy flag covers the whole run. Starts that arrive while a run is in progress are dropped.

Top module: `tws_top`

## Requirements
- R1: After a synchronous active-low reset, `pattern_out` is 0, and `busy` and `done` are both 0.
- R2: A write with `wr_en` high stores `wr_data` at `wr_addr`. Bits [15:0] of a stored word are its output pattern and bits [23:16] are its hold field.
- R3: A start is accepted at a clock edge with `start` high while idle and with a nonzero `word_count`. `busy` is high from that edge onward, and the first word's pattern appears on `pattern_out` at the following edge.
- R4: Each word's pattern stays on `pattern_out` for exactly H clock cycles, with H = 5 + 4 × hold field and an upper limit of 1020. The next word's pattern appears H edges after the current one appeared.
- R5: Words are read from consecutive addresses starting at `start_addr`. The address wraps from 1023 to 0.
- R6: `done` is high for exactly one cycle, at the edge where the last word's hold ends. `busy` falls at that same edge. `pattern_out` keeps the last word's pattern afterwards.
- R7: A start that arrives while `busy` is high has no effect on the running sequence or on the outputs after it.
- R8: A start with `word_count` equal to 0 is ignored. `busy` stays 0, `done` stays 0 and `pattern_out` is unchanged.
- R9: A hold field of 254 or 255 saturates to 1020 cycles, and a field of 253 gives 1017 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 10 | Table write address |
| wr_data | input | 24 | Table word: hold field [23:16], pattern [15:0] |
| start | input | 1 | Run request |
| start_addr | input | 10 | First table address of the run |
| word_count | input | 11 | Number of words to play (1 to 1024) |
| pattern_out | output | 16 | Registered output pattern |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
The bench counts the edges after an accepted start. `busy` is due one edge after the start is sampled. The first pattern is due two edges after it. Each later pattern, and the final `done` pulse, is due the sum of the preceding computed holds after the first pattern. The driver turns the table contents it wrote into items that carry the exact cycle at which each is due. The monitor samples on the falling edge and compares an item only in its due cycle, so an item that arrives early or late fails. Dropped starts and zero counts are checked by expecting unchanged outputs in the cycles where a wrongly accepted start would have shown.

// File: rtl/tws_pkg.sv
// Shared types for the timing word sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package tws_pkg;
    // Sequencer control states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_HOLD = 2'd2
    } seq_state_t;
endpackage

// File: rtl/tws_table.sv
// Word table: synchronous write, combinational read.
// Assumes: reads and writes to the same address in one cycle return the old word.
module tws_table #(
    parameter int ADDR_W = 10,
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    // Store a word on a write strobe
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Present the addressed word
    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/tws_hold_calc.sv
// Converts a hold field to a cycle count: BASE + field*STEP, limited to MAX.
// Assumes: MAX >= BASE and MAX fits in CNT_W bits.
module tws_hold_calc #(
    parameter int HOLD_W = 8,
    parameter int CNT_W  = 10,
    parameter int BASE   = 5,
    parameter int STEP   = 4,
    parameter int MAX    = 1020
) (
    input  logic [HOLD_W-1:0] hold_field,
    output logic [CNT_W-1:0]  hold_cycles
);
    logic [31:0] raw;

    // Scale the field and clamp at the upper limit
    always_comb begin
        raw = 32'(BASE) + 32'(hold_field) * 32'(STEP);
        if (raw > 32'(MAX)) hold_cycles = CNT_W'(MAX);
        else                hold_cycles = CNT_W'(raw);
    end
endmodule

// File: rtl/tws_ctrl.sv
// Run control: accepts a start, walks addresses, registers each pattern and
// counts down its hold before taking the next word.
// Assumes: hold_cycles belongs to the word at rd_addr and is at least 1.
module tws_ctrl
    import tws_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int OUT_W  = 16,
    parameter int CNT_W  = 10,
    parameter int BASE   = 5,
    parameter int MAX    = 1020
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W:0]   word_count,
    input  logic [OUT_W-1:0]  rd_pattern,
    input  logic [CNT_W-1:0]  hold_cycles,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [OUT_W-1:0]  pattern_out,
    output logic              busy,
    output logic              done
);
    seq_state_t         state;
    logic [ADDR_W:0]    remain;
    logic [CNT_W-1:0]   cnt;

    // Sequencer state, address, countdown and registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            rd_addr     <= '0;
            remain      <= '0;
            cnt         <= '0;
            pattern_out <= '0;
            busy        <= 1'b0;
            done        <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start && (word_count != '0)) begin
                        rd_addr <= start_addr;
                        remain  <= word_count;
                        busy    <= 1'b1;
                        state   <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    pattern_out <= rd_pattern;
                    cnt         <= hold_cycles - CNT_W'(1);
                    rd_addr     <= rd_addr + ADDR_W'(1);
                    remain      <= remain - (ADDR_W+1)'(1);
                    state       <= ST_HOLD;
                end
                ST_HOLD: begin
                    if (cnt != '0) begin
                        cnt <= cnt - CNT_W'(1);
                    end else if (remain == '0) begin
                        done  <= 1'b1;
                        busy  <= 1'b0;
                        state <= ST_IDLE;
                    end else begin
                        pattern_out <= rd_pattern;
                        cnt         <= hold_cycles - CNT_W'(1);
                        rd_addr     <= rd_addr + ADDR_W'(1);
                        remain      <= remain - (ADDR_W+1)'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Pattern holds steady while a countdown is running
    assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && cnt != '0) |=> $stable(pattern_out));

    // Done lasts one cycle
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // Done marks the end of a busy run
    assert_done_ends_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // A start during a hold leaves the walk untouched
    assert_ignore_busy_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy && state == ST_HOLD && cnt != '0) |=> ($stable(rd_addr) && $stable(remain)));

    // A zero-length start is not accepted
    assert_count_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && word_count == '0) |=> !busy);

    // The converted hold stays inside its legal range
    always_comb begin
        if (rst_n) begin
            assert_hold_range_R9: assert (hold_cycles >= CNT_W'(BASE) && hold_cycles <= CNT_W'(MAX));
        end
    end
endmodule

// File: rtl/tws_top.sv
// Timing word sequencer top: table, hold converter and run control.
// Assumes: table words put the hold field above the pattern field.
module tws_top #(
    parameter int ADDR_W = 10,
    parameter int OUT_W  = 16,
    parameter int HOLD_W = 8,
    parameter int BASE   = 5,
    parameter int STEP   = 4,
    parameter int MAX    = 1020
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [OUT_W+HOLD_W-1:0]    wr_data,
    input  logic                       start,
    input  logic [ADDR_W-1:0]          start_addr,
    input  logic [ADDR_W:0]            word_count,
    output logic [OUT_W-1:0]           pattern_out,
    output logic                       busy,
    output logic                       done
);
    localparam int WORD_W = OUT_W + HOLD_W;
    localparam int CNT_W  = $clog2(MAX + 1);

    logic [ADDR_W-1:0] rd_addr;
    logic [WORD_W-1:0] rd_data;
    logic [CNT_W-1:0]  hold_cycles;

    tws_table #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_table (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    tws_hold_calc #(.HOLD_W(HOLD_W), .CNT_W(CNT_W), .BASE(BASE), .STEP(STEP), .MAX(MAX)) u_hold (
        .hold_field  (rd_data[WORD_W-1:OUT_W]),
        .hold_cycles (hold_cycles)
    );

    tws_ctrl #(.ADDR_W(ADDR_W), .OUT_W(OUT_W), .CNT_W(CNT_W), .BASE(BASE), .MAX(MAX)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .start_addr  (start_addr),
        .word_count  (word_count),
        .rd_pattern  (rd_data[OUT_W-1:0]),
        .hold_cycles (hold_cycles),
        .rd_addr     (rd_addr),
        .pattern_out (pattern_out),
        .busy        (busy),
        .done        (done)
    );
endmodule

// File: tb/test_tws_top.sv
// Scoreboard bench: the driver queues timed expectations, the monitor checks them.
module test_tws_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [9:0]  wr_addr = '0;
    logic [23:0] wr_data = '0;
    logic        start = 1'b0;
    logic [9:0]  start_addr = '0;
    logic [10:0] word_count = '0;
    logic [15:0] pattern_out;
    logic        busy;
    logic        done;

    tws_top i_tws_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .start(start), .start_addr(start_addr), .word_count(word_count),
        .pattern_out(pattern_out), .busy(busy), .done(done)
    );

    always #2 clk = ~clk;

    typedef struct {
        int    due;
        int    kind;   // 0 pattern_out, 1 done, 2 busy
        int    val;
        string req;
    } item_t;

    item_t       exp_q[$];
    item_t       it;
    int          cyc = 0;
    int          checks = 0;
    int          fails = 0;
    bit          finished = 0;
    logic [23:0] tb_mem [1024];
    int          last_out = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int hold_of(input int f);
        int h;
        h = 5 + 4 * f;
        if (h > 1020) h = 1020;
        return h;
    endfunction

    task automatic chk(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic push(input int due, input int kind, input int val, input string req);
        item_t x;
        x.due = due; x.kind = kind; x.val = val; x.req = req;
        exp_q.push_back(x);
    endtask

    // Monitor: compare every item in its due cycle
    always @(negedge clk) begin
        while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
            int act;
            it = exp_q.pop_front();
            act = (it.kind == 0) ? int'(pattern_out) : (it.kind == 1) ? int'(done) : int'(busy);
            checks++;
            if (it.due != cyc || act != it.val) begin
                fails++;
                $display("FAIL %s kind=%0d cycle=%0d actual=%0h expected=%0h",
                         it.req, it.kind, cyc, act, it.val);
            end
        end
    end

    task automatic wr(input int a, input logic [23:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 10'(a); wr_data = d;
        tb_mem[a] = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_empty();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    // Driver: queue the expected timeline, then issue the start
    task automatic run_seq(input int sa, input int n, input bit rogue, input string req);
        int t;
        int nstart;
        logic [23:0] w;
        @(negedge clk);
        nstart = cyc;
        if (n == 0) begin
            push(nstart + 1, 2, 0, req);
            push(nstart + 2, 0, last_out, req);
            push(nstart + 2, 1, 0, req);
        end else begin
            push(nstart + 1, 2, 1, "R3");
            t = nstart + 2;
            for (int k = 0; k < n; k++) begin
                w = tb_mem[(sa + k) % 1024];
                push(t, 0, int'(w[15:0]), req);
                t += hold_of(int'(w[23:16]));
                last_out = int'(w[15:0]);
            end
            push(t, 1, 1, "R6");
            push(t, 2, 0, "R6");
            push(t, 0, last_out, "R6");
            push(t + 1, 1, 0, "R6");
        end
        start = 1'b1; start_addr = 10'(sa); word_count = 11'(n);
        @(negedge clk);
        start = 1'b0;
        if (rogue) begin
            @(negedge clk);
            @(negedge clk);
            start = 1'b1; start_addr = 10'd10; word_count = 11'd1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_empty();
        push(cyc + 20, 0, last_out, rogue ? "R7" : req);
        push(cyc + 20, 2, 0, rogue ? "R7" : req);
        wait_empty();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", int'(pattern_out), 0);
        chk("R1", int'(busy), 0);
        chk("R1", int'(done), 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R2: fields are hold [23:16], pattern [15:0]
        wr(0, 24'h00_A5A5);
        wr(1, 24'h01_1234);
        wr(2, 24'h02_FFFF);
        wr(3, 24'h00_0001);
        wr(10, 24'hFF_0F0F);
        wr(11, 24'hFE_F0F0);
        wr(12, 24'hFD_5555);
        wr(1022, 24'h03_C3C3);
        wr(1023, 24'h00_3C3C);
        // R2 R3 R4: basic run with varied holds
        run_seq(0, 4, 1'b0, "R4");
        // R9: saturating holds
        run_seq(10, 3, 1'b0, "R9");
        // R5: wrap from the last address to 0
        run_seq(1022, 3, 1'b0, "R5");
        // R7: start while busy is dropped
        run_seq(1, 2, 1'b1, "R4");
        // R8: zero count is ignored
        run_seq(2, 0, 1'b0, "R8");
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule